// File: doc/BRIEF.md
# Display Command Byte Parser

This block sits behind a serial display link and turns a stream of command bytes into the configuration state of a monochrome matrix display controller. Each byte arrives with a one-cycle valid strobe. Some opcodes stand alone. Some are pairs where the lowest changed bit selects one of two settings, and one whole range of opcodes carries its value in its low bits. The remaining opcodes are followed by one or two argument bytes. The parser collects these argument bytes and masks each one to its legal field before it writes the setting.

The settings are held in registers and driven straight out as ports. When a column window command or a page window command has collected its last argument, the parser raises a one-cycle pulse so that downstream addressing logic can reload its pointers. A byte that matches no known opcode is dropped, and the parser stays ready for the next opcode. Gaps of any length between the bytes of one command are allowed.

Top module: `display_cmd_parser`

## Requirements
- R1: After synchronous reset the outputs read as follows: display off, contrast 0x7F, addressing mode 0, column window 0 to 127, page window 0 to 7, multiplex field 0x3F. Every other setting is 0, and no window pulse is raised.
- R2: Opcodes 0xAE/0xAF clear/set display on. Opcodes 0xA6/0xA7 clear/set inverse. Opcodes 0xA4/0xA5 clear/set entire-display-on.
- R3: Any opcode from 0x40 to 0x7F sets the start line to the opcode's bits 5:0.
- R4: Opcodes 0xA0/0xA1 clear/set segment remap. Opcodes 0xC0/0xC8 clear/set reversed COM scan.
- R5: Opcode 0x81 followed by one argument byte sets contrast to all 8 bits of that argument.
- R6: These opcodes each take one argument and mask it. 0x20 keeps bits 1:0 as addressing mode. 0xA8 keeps bits 5:0 as multiplex ratio. 0xD3 keeps bits 5:0 as display offset. 0xDA keeps bits 5:4 as COM pin configuration. 0xDB keeps bits 6:4 as VCOMH level. 0x8D keeps bit 2 as charge pump enable. 0xD5 and 0xD9 keep all 8 bits as clock divide and pre-charge.
- R7: Opcode 0x21 takes two arguments. It sets column start to bits 6:0 of the first and column end to bits 6:0 of the second. The column pulse is high for exactly the one cycle after the second argument is accepted.
- R8: Opcode 0x22 takes two arguments. It sets page start to bits 2:0 of the first and page end to bits 2:0 of the second. The page pulse is high for exactly the one cycle after the second argument is accepted.
- R9: An argument byte is never decoded as an opcode, even when its value equals one.
- R10: An unknown opcode changes no output, and the byte that follows it is decoded as an opcode.
- R11: Cycles without valid change no output. Idle cycles between the bytes of one command do not disturb the command.
- R12: A setting changes on the clock edge that accepts the byte completing its command. Bytes presented on consecutive cycles are each taken in turn.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| byte_valid | input | 1 | Command byte strobe |
| byte_in | input | 8 | Command or argument byte |
| contrast | output | 8 | Contrast level |
| disp_on | output | 1 | Display enabled |
| inverse | output | 1 | Inverted pixel output |
| all_on | output | 1 | Entire display forced on |
| addr_mode | output | 2 | Memory addressing mode |
| seg_remap | output | 1 | Segment remap |
| com_rev | output | 1 | Reversed COM scan |
| mux_ratio | output | 6 | Multiplex ratio field |
| disp_offset | output | 6 | Display offset |
| start_line | output | 6 | Display start line |
| com_cfg | output | 2 | COM pin configuration field |
| clk_div | output | 8 | Clock divide / oscillator byte |
| precharge | output | 8 | Pre-charge period byte |
| vcom_level | output | 3 | VCOMH deselect level |
| pump_en | output | 1 | Charge pump enable |
| col_start | output | 7 | Column window start |
| col_end | output | 7 | Column window end |
| page_start | output | 3 | Page window start |
| page_end | output | 3 | Page window end |
| col_win_done | output | 1 | One-cycle pulse on column window update |
| page_win_done | output | 1 | One-cycle pulse on page window update |

## Verification
Each toggle pair is driven in both directions, which separates a decode of the low opcode bit from a plain "set" decode. Arguments are sent with all bits set outside the legal field, so a missing mask or a shifted field shows up. Opcode-valued arguments, unknown opcodes and long idle gaps inside a command each test the parser's state tracking rather than its decoding. A burst of back-to-back bytes, checked cycle by cycle, pins down the one-edge update latency and the pulse width.

// File: rtl/dcp_pkg.sv
package dcp_pkg;

    localparam int BYTE_W  = 8;
    localparam int COL_W   = 7;
    localparam int PAGE_W  = 3;
    localparam int LINE_W  = 6;
    localparam int MUX_W   = 6;
    localparam int VCOM_W  = 3;
    localparam int AMODE_W = 2;
    localparam int PINS_W  = 2;

    localparam logic [BYTE_W-1:0] CONTRAST_RST = 8'h7F;
    localparam logic [MUX_W-1:0]  MUX_RST      = '1;
    localparam logic [COL_W-1:0]  COL_END_RST  = '1;
    localparam logic [PAGE_W-1:0] PAGE_END_RST = '1;

    typedef enum logic [3:0] {
        OP_NONE,
        OP_SINGLE,
        OP_CONTRAST,
        OP_AMODE,
        OP_COLWIN,
        OP_PAGEWIN,
        OP_MUX,
        OP_OFFSET,
        OP_COMCFG,
        OP_CLKDIV,
        OP_PRECH,
        OP_VCOM,
        OP_PUMP
    } op_e;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_ARG0,
        ST_ARG1
    } st_e;

    typedef struct packed {
        op_e        op;
        logic [1:0] nargs;
    } dec_t;

    typedef struct packed {
        logic              fire;
        op_e               op;
        logic [BYTE_W-1:0] lead;
        logic [BYTE_W-1:0] a0;
        logic [BYTE_W-1:0] a1;
    } evt_t;

    typedef struct packed {
        logic [BYTE_W-1:0]  contrast;
        logic               disp_on;
        logic               inverse;
        logic               all_on;
        logic [AMODE_W-1:0] addr_mode;
        logic               seg_remap;
        logic               com_rev;
        logic [MUX_W-1:0]   mux_ratio;
        logic [LINE_W-1:0]  disp_offset;
        logic [LINE_W-1:0]  start_line;
        logic [PINS_W-1:0]  com_cfg;
        logic [BYTE_W-1:0]  clk_div;
        logic [BYTE_W-1:0]  precharge;
        logic [VCOM_W-1:0]  vcom_level;
        logic               pump_en;
        logic [COL_W-1:0]   col_start;
        logic [COL_W-1:0]   col_end;
        logic [PAGE_W-1:0]  page_start;
        logic [PAGE_W-1:0]  page_end;
    } cfg_t;

    function automatic cfg_t cfg_reset();
        cfg_t c;
        c             = '0;
        c.contrast    = CONTRAST_RST;
        c.mux_ratio   = MUX_RST;
        c.col_end     = COL_END_RST;
        c.page_end    = PAGE_END_RST;
        return c;
    endfunction

    function automatic logic is_single(input logic [BYTE_W-1:0] b);
        logic hit;
        hit = (b[7:6] == 2'b01);
        case (b)
            8'hA0, 8'hA1, 8'hA4, 8'hA5, 8'hA6, 8'hA7,
            8'hAE, 8'hAF, 8'hC0, 8'hC8: hit = 1'b1;
            default: ;
        endcase
        return hit;
    endfunction

    function automatic dec_t decode_op(input logic [BYTE_W-1:0] b);
        dec_t d;
        d.op    = OP_NONE;
        d.nargs = 2'd0;
        case (b)
            8'h81: begin d.op = OP_CONTRAST; d.nargs = 2'd1; end
            8'h20: begin d.op = OP_AMODE;    d.nargs = 2'd1; end
            8'h21: begin d.op = OP_COLWIN;   d.nargs = 2'd2; end
            8'h22: begin d.op = OP_PAGEWIN;  d.nargs = 2'd2; end
            8'hA8: begin d.op = OP_MUX;      d.nargs = 2'd1; end
            8'hD3: begin d.op = OP_OFFSET;   d.nargs = 2'd1; end
            8'hDA: begin d.op = OP_COMCFG;   d.nargs = 2'd1; end
            8'hD5: begin d.op = OP_CLKDIV;   d.nargs = 2'd1; end
            8'hD9: begin d.op = OP_PRECH;    d.nargs = 2'd1; end
            8'hDB: begin d.op = OP_VCOM;     d.nargs = 2'd1; end
            8'h8D: begin d.op = OP_PUMP;     d.nargs = 2'd1; end
            default: if (is_single(b)) d.op = OP_SINGLE;
        endcase
        return d;
    endfunction

    function automatic logic takes_two(input op_e op);
        return (op == OP_COLWIN) || (op == OP_PAGEWIN);
    endfunction

endpackage

// File: rtl/dcp_decode.sv
module dcp_decode
    import dcp_pkg::*;
(
    input  logic [BYTE_W-1:0] byte_in,
    output dec_t              dec
);
    always_comb dec = decode_op(byte_in);
endmodule

// File: rtl/dcp_seq.sv
module dcp_seq
    import dcp_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              byte_valid,
    input  logic [BYTE_W-1:0] byte_in,
    input  dec_t              dec,
    output evt_t              evt,
    output logic              idle
);
    st_e               st;
    op_e               pend;
    logic [BYTE_W-1:0] first;

    always_ff @(posedge clk) begin
        if (rst) begin
            st    <= ST_IDLE;
            pend  <= OP_NONE;
            first <= '0;
        end else if (byte_valid) begin
            case (st)
                ST_IDLE: begin
                    if (dec.nargs != 2'd0) begin
                        pend <= dec.op;
                        st   <= ST_ARG0;
                    end
                end
                ST_ARG0: begin
                    if (takes_two(pend)) begin
                        first <= byte_in;
                        st    <= ST_ARG1;
                    end else begin
                        st <= ST_IDLE;
                    end
                end
                default: st <= ST_IDLE;
            endcase
        end
    end

    always_comb begin
        evt      = '0;
        evt.op   = OP_NONE;
        if (byte_valid) begin
            case (st)
                ST_IDLE: begin
                    if (dec.op == OP_SINGLE) begin
                        evt.fire = 1'b1;
                        evt.op   = OP_SINGLE;
                        evt.lead = byte_in;
                    end
                end
                ST_ARG0: begin
                    if (!takes_two(pend)) begin
                        evt.fire = 1'b1;
                        evt.op   = pend;
                        evt.a0   = byte_in;
                    end
                end
                default: begin
                    evt.fire = 1'b1;
                    evt.op   = pend;
                    evt.a0   = first;
                    evt.a1   = byte_in;
                end
            endcase
        end
    end

    assign idle = (st == ST_IDLE);
endmodule

// File: rtl/dcp_regs.sv
module dcp_regs
    import dcp_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  evt_t evt,
    output cfg_t cfg,
    output logic col_done,
    output logic page_done
);
    always_ff @(posedge clk) begin
        if (rst) begin
            cfg       <= cfg_reset();
            col_done  <= 1'b0;
            page_done <= 1'b0;
        end else begin
            col_done  <= evt.fire && (evt.op == OP_COLWIN);
            page_done <= evt.fire && (evt.op == OP_PAGEWIN);
            if (evt.fire) begin
                case (evt.op)
                    OP_SINGLE: begin
                        if (evt.lead[7:6] == 2'b01)
                            cfg.start_line <= evt.lead[LINE_W-1:0];
                        case (evt.lead)
                            8'hA0, 8'hA1: cfg.seg_remap <= evt.lead[0];
                            8'hA4, 8'hA5: cfg.all_on    <= evt.lead[0];
                            8'hA6, 8'hA7: cfg.inverse   <= evt.lead[0];
                            8'hAE, 8'hAF: cfg.disp_on   <= evt.lead[0];
                            8'hC0, 8'hC8: cfg.com_rev   <= evt.lead[3];
                            default: ;
                        endcase
                    end
                    OP_CONTRAST: cfg.contrast    <= evt.a0;
                    OP_AMODE:    cfg.addr_mode   <= evt.a0[AMODE_W-1:0];
                    OP_MUX:      cfg.mux_ratio   <= evt.a0[MUX_W-1:0];
                    OP_OFFSET:   cfg.disp_offset <= evt.a0[LINE_W-1:0];
                    OP_COMCFG:   cfg.com_cfg     <= evt.a0[5:4];
                    OP_CLKDIV:   cfg.clk_div     <= evt.a0;
                    OP_PRECH:    cfg.precharge   <= evt.a0;
                    OP_VCOM:     cfg.vcom_level  <= evt.a0[6:4];
                    OP_PUMP:     cfg.pump_en     <= evt.a0[2];
                    OP_COLWIN: begin
                        cfg.col_start <= evt.a0[COL_W-1:0];
                        cfg.col_end   <= evt.a1[COL_W-1:0];
                    end
                    OP_PAGEWIN: begin
                        cfg.page_start <= evt.a0[PAGE_W-1:0];
                        cfg.page_end   <= evt.a1[PAGE_W-1:0];
                    end
                    default: ;
                endcase
            end
        end
    end
endmodule

// File: rtl/display_cmd_parser.sv
module display_cmd_parser
    import dcp_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              byte_valid,
    input  logic [BYTE_W-1:0] byte_in,
    output logic [BYTE_W-1:0] contrast,
    output logic              disp_on,
    output logic              inverse,
    output logic              all_on,
    output logic [AMODE_W-1:0] addr_mode,
    output logic              seg_remap,
    output logic              com_rev,
    output logic [MUX_W-1:0]  mux_ratio,
    output logic [LINE_W-1:0] disp_offset,
    output logic [LINE_W-1:0] start_line,
    output logic [PINS_W-1:0] com_cfg,
    output logic [BYTE_W-1:0] clk_div,
    output logic [BYTE_W-1:0] precharge,
    output logic [VCOM_W-1:0] vcom_level,
    output logic              pump_en,
    output logic [COL_W-1:0]  col_start,
    output logic [COL_W-1:0]  col_end,
    output logic [PAGE_W-1:0] page_start,
    output logic [PAGE_W-1:0] page_end,
    output logic              col_win_done,
    output logic              page_win_done
);
    dec_t dec;
    evt_t evt;
    cfg_t cfg;
    logic seq_idle;

    dcp_decode u_decode (
        .byte_in (byte_in),
        .dec     (dec)
    );

    dcp_seq u_seq (
        .clk        (clk),
        .rst        (rst),
        .byte_valid (byte_valid),
        .byte_in    (byte_in),
        .dec        (dec),
        .evt        (evt),
        .idle       (seq_idle)
    );

    dcp_regs u_regs (
        .clk       (clk),
        .rst       (rst),
        .evt       (evt),
        .cfg       (cfg),
        .col_done  (col_win_done),
        .page_done (page_win_done)
    );

    assign contrast    = cfg.contrast;
    assign disp_on     = cfg.disp_on;
    assign inverse     = cfg.inverse;
    assign all_on      = cfg.all_on;
    assign addr_mode   = cfg.addr_mode;
    assign seg_remap   = cfg.seg_remap;
    assign com_rev     = cfg.com_rev;
    assign mux_ratio   = cfg.mux_ratio;
    assign disp_offset = cfg.disp_offset;
    assign start_line  = cfg.start_line;
    assign com_cfg     = cfg.com_cfg;
    assign clk_div     = cfg.clk_div;
    assign precharge   = cfg.precharge;
    assign vcom_level  = cfg.vcom_level;
    assign pump_en     = cfg.pump_en;
    assign col_start   = cfg.col_start;
    assign col_end     = cfg.col_end;
    assign page_start  = cfg.page_start;
    assign page_end    = cfg.page_end;
endmodule

// File: rtl/dcp_checker.sv
module dcp_checker (
    input logic       clk,
    input logic       rst,
    input logic       byte_valid,
    input logic [7:0] byte_in,
    input logic       seq_idle,
    input logic       disp_on,
    input logic [7:0] contrast,
    input logic [5:0] start_line,
    input logic       col_win_done,
    input logic       page_win_done
);
    // R2: opcode 0xAF taken while idle turns the display on
    p_display_on_r2: assert property (@(posedge clk) disable iff (rst)
        (seq_idle && byte_valid && byte_in == 8'hAF) |=> disp_on);

    // R3: start line follows the low bits of a range opcode
    p_start_line_r3: assert property (@(posedge clk) disable iff (rst)
        (seq_idle && byte_valid && byte_in[7:6] == 2'b01)
        |=> (start_line == $past(byte_in[5:0])));

    // R7: column pulse only after an accepted byte
    p_col_pulse_r7: assert property (@(posedge clk) disable iff (rst)
        col_win_done |-> $past(byte_valid));

    // R8: page pulse only after an accepted byte, never with the column pulse
    p_page_pulse_r8: assert property (@(posedge clk) disable iff (rst)
        page_win_done |-> ($past(byte_valid) && !col_win_done));

    // R9: argument bytes never touch the display switch
    p_arg_no_opcode_r9: assert property (@(posedge clk) disable iff (rst)
        (!seq_idle && byte_valid) |=> $stable(disp_on));

    // R11: no valid, no change
    p_quiet_r11: assert property (@(posedge clk) disable iff (rst)
        !byte_valid |=> ($stable(contrast) && $stable(disp_on) && $stable(start_line)
                         && !col_win_done && !page_win_done));
endmodule

bind display_cmd_parser dcp_checker u_dcp_checker (
    .clk           (clk),
    .rst           (rst),
    .byte_valid    (byte_valid),
    .byte_in       (byte_in),
    .seq_idle      (seq_idle),
    .disp_on       (disp_on),
    .contrast      (contrast),
    .start_line    (start_line),
    .col_win_done  (col_win_done),
    .page_win_done (page_win_done)
);

// File: tb/display_cmd_parser_bench.sv
module display_cmd_parser_bench;
    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       byte_valid = 1'b0;
    logic [7:0] byte_in = 8'h00;

    logic [7:0] contrast, clk_div, precharge;
    logic       disp_on, inverse, all_on, seg_remap, com_rev, pump_en;
    logic [1:0] addr_mode, com_cfg;
    logic [5:0] mux_ratio, disp_offset, start_line;
    logic [2:0] vcom_level, page_start, page_end;
    logic [6:0] col_start, col_end;
    logic       col_win_done, page_win_done;

    int checks = 0;
    int errors = 0;

    always #5 clk = ~clk;

    display_cmd_parser u_display_cmd_parser (
        .clk(clk), .rst(rst), .byte_valid(byte_valid), .byte_in(byte_in),
        .contrast(contrast), .disp_on(disp_on), .inverse(inverse), .all_on(all_on),
        .addr_mode(addr_mode), .seg_remap(seg_remap), .com_rev(com_rev),
        .mux_ratio(mux_ratio), .disp_offset(disp_offset), .start_line(start_line),
        .com_cfg(com_cfg), .clk_div(clk_div), .precharge(precharge),
        .vcom_level(vcom_level), .pump_en(pump_en), .col_start(col_start),
        .col_end(col_end), .page_start(page_start), .page_end(page_end),
        .col_win_done(col_win_done), .page_win_done(page_win_done)
    );

    task automatic chk(input string tag, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, exp);
        end
    endtask

    // one byte, then valid dropped; returns in the cycle after the accepting edge
    task automatic send(input logic [7:0] b);
        @(negedge clk);
        byte_valid = 1'b1;
        byte_in    = b;
        @(negedge clk);
        byte_valid = 1'b0;
        byte_in    = 8'h00;
    endtask

    task automatic t_reset();
        chk("R1 disp_on", disp_on, 0);
        chk("R1 contrast", contrast, 8'h7F);
        chk("R1 addr_mode", addr_mode, 0);
        chk("R1 col_start", col_start, 0);
        chk("R1 col_end", col_end, 127);
        chk("R1 page_start", page_start, 0);
        chk("R1 page_end", page_end, 7);
        chk("R1 mux_ratio", mux_ratio, 8'h3F);
        chk("R1 others", {inverse, all_on, seg_remap, com_rev, pump_en,
                          disp_offset, start_line, com_cfg, vcom_level}, 0);
        chk("R1 clk_div/precharge", {clk_div, precharge}, 0);
        chk("R1 pulses", {col_win_done, page_win_done}, 0);
    endtask

    task automatic t_toggles();
        send(8'hAF); chk("R2 display on", disp_on, 1);
        send(8'hA7); chk("R2 inverse set", inverse, 1);
        send(8'hA5); chk("R2 entire on set", all_on, 1);
        send(8'hA6); chk("R2 inverse clear", inverse, 0);
        send(8'hA4); chk("R2 entire on clear", all_on, 0);
        send(8'hAE); chk("R2 display off", disp_on, 0);
    endtask

    task automatic t_start_line();
        send(8'h7F); chk("R3 start line 0x7F", start_line, 63);
        send(8'h55); chk("R3 start line 0x55", start_line, 8'h15);
        send(8'h40); chk("R3 start line 0x40", start_line, 0);
    endtask

    task automatic t_remap();
        send(8'hA1); chk("R4 remap set", seg_remap, 1);
        send(8'hC8); chk("R4 com reverse set", com_rev, 1);
        send(8'hC0); chk("R4 com reverse clear", com_rev, 0);
        send(8'hA0); chk("R4 remap clear", seg_remap, 0);
    endtask

    task automatic t_contrast();
        send(8'h81); chk("R5 contrast held before arg", contrast, 8'h7F);
        send(8'h3C); chk("R5 contrast written", contrast, 8'h3C);
    endtask

    task automatic t_one_arg();
        send(8'h20); send(8'hFE); chk("R6 addr mode mask", addr_mode, 2);
        send(8'hA8); send(8'hD5); chk("R6 mux mask", mux_ratio, 8'h15);
        send(8'hD3); send(8'hC5); chk("R6 offset mask", disp_offset, 5);
        send(8'hDA); send(8'h12); chk("R6 com pins field", com_cfg, 1);
        send(8'hDA); send(8'hEF); chk("R6 com pins field high", com_cfg, 2);
        send(8'hDB); send(8'hB0); chk("R6 vcom field", vcom_level, 3);
        send(8'h8D); send(8'h14); chk("R6 pump on", pump_en, 1);
        send(8'h8D); send(8'hFB); chk("R6 pump off", pump_en, 0);
        send(8'hD5); send(8'h80); chk("R6 clock divide", clk_div, 8'h80);
        send(8'hD9); send(8'hF1); chk("R6 precharge", precharge, 8'hF1);
    endtask

    task automatic t_col_window();
        send(8'h21);
        send(8'h85);
        chk("R7 no pulse after first arg", col_win_done, 0);
        chk("R7 start held after first arg", col_start, 0);
        send(8'h9A);
        chk("R7 column pulse", col_win_done, 1);
        chk("R7 column start", col_start, 5);
        chk("R7 column end", col_end, 8'h1A);
        @(negedge clk);
        chk("R7 pulse one cycle", col_win_done, 0);
    endtask

    task automatic t_page_window();
        send(8'h22);
        send(8'hFB);
        chk("R8 no pulse after first arg", page_win_done, 0);
        send(8'h0D);
        chk("R8 page pulse", page_win_done, 1);
        chk("R8 column pulse quiet", col_win_done, 0);
        chk("R8 page start", page_start, 3);
        chk("R8 page end", page_end, 5);
        @(negedge clk);
        chk("R8 pulse one cycle", page_win_done, 0);
    endtask

    task automatic t_args_not_opcodes();
        send(8'h81); send(8'hAF);
        chk("R9 opcode value as contrast", contrast, 8'hAF);
        chk("R9 display not switched", disp_on, 0);
        send(8'h21); send(8'h22); send(8'h21);
        chk("R9 window args taken literally", {col_start, col_end}, {7'h22, 7'h21});
        chk("R9 no page pulse", page_win_done, 0);
    endtask

    task automatic t_unknown();
        send(8'hE3);
        chk("R10 unknown leaves contrast", contrast, 8'hAF);
        send(8'hAF);
        chk("R10 next byte is opcode", disp_on, 1);
        send(8'hFF); send(8'h00);
        chk("R10 byte after 0xFF decoded as opcode", start_line, 0);
        send(8'h00); send(8'h48);
        chk("R10 byte after 0x00 decoded as opcode", start_line, 8);
    endtask

    task automatic t_gaps();
        send(8'h22);
        repeat (5) @(negedge clk);
        chk("R11 gap holds page start", page_start, 3);
        send(8'h01);
        repeat (7) @(negedge clk);
        chk("R11 no pulse during gap", page_win_done, 0);
        send(8'h06);
        chk("R11 command completes after gaps", {page_start, page_end}, {3'd1, 3'd6});
    endtask

    task automatic t_back_to_back();
        @(negedge clk); byte_valid = 1'b1; byte_in = 8'hAE;
        @(negedge clk); chk("R12 off next cycle", disp_on, 0); byte_in = 8'h41;
        @(negedge clk); chk("R12 start line next cycle", start_line, 1); byte_in = 8'h81;
        @(negedge clk); byte_in = 8'h5A;
        @(negedge clk); chk("R12 contrast next cycle", contrast, 8'h5A); byte_in = 8'h21;
        @(negedge clk); byte_in = 8'h10;
        @(negedge clk); byte_in = 8'h20;
        @(negedge clk); chk("R12 burst column pulse", col_win_done, 1);
        chk("R12 burst column window", {col_start, col_end}, {7'h10, 7'h20});
        byte_in = 8'hAF;
        @(negedge clk); chk("R12 pulse ends under burst", col_win_done, 0);
        chk("R12 on after burst", disp_on, 1);
        byte_valid = 1'b0; byte_in = 8'h00;
    endtask

    task automatic run_all();
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        t_reset();
        t_toggles();
        t_start_line();
        t_remap();
        t_contrast();
        t_one_arg();
        t_col_window();
        t_page_window();
        t_args_not_opcodes();
        t_unknown();
        t_gaps();
        t_back_to_back();
        repeat (2) @(negedge clk);
    endtask

    initial begin
        fork
            run_all();
            begin
                repeat (100000) @(posedge clk);
                checks++;
                errors++;
                $display("FAIL R12 watchdog actual=hung expected=finished");
            end
        join_any
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule